// File: doc/BRIEF.md
# Bus-Master Region Permission Checker

This block checks each bus request against a small table of address regions. Every region holds an inclusive start address, an inclusive end address, a 32-bit permission word and a valid flag. A request carries an address, a 4-bit master number, a write flag and two protection bits. One cycle later the block returns either a grant or an access error. The fabric uses this result to let the transfer go ahead or to stop it with an error response.

Masters fall into two classes. Masters 0 to 3 are processor-class. Each has a 6-bit field with user-mode read/write/execute enables and a 2-bit supervisor-rights code. The protection bits choose user or supervisor mode, and they separate an instruction fetch from a data access. Masters 4 to 7 are data-movement engines. Each has only a read enable and a write enable, and its protection bits are ignored.

Software programs the table through a simple write port. Writing a region's permission word through its main slot clears that region's valid flag. A second alias slot writes the same word and leaves the valid flag as it was.

Top module: `rgn_guard`

## Requirements
- R1: After reset, region 0 is valid, spans addresses 0 to all-ones and grants every access type to masters 0 to 7. Its permission word is 32'hFF1C71C7. All other regions are invalid. resp_valid, resp_grant and resp_error are low.
- R2: A request sampled with req_valid high at a clock edge produces resp_valid high after that edge, together with exactly one of resp_grant or resp_error. With no request, all three outputs are low.
- R3: A region matches only when it is valid and start <= req_addr <= end, both bounds inclusive. A request that matches no region gets resp_error.
- R4: A request is granted when at least one matching region permits it. A region that denies the request does not block a grant from another matching region.
- R5: For master m in 0..3, the field is perm[6m+5:6m]. Field bit 0 is user execute, bit 1 is user write and bit 2 is user read. The access type is write when req_write=1, data read when req_write=0 and req_prot[0]=1, and instruction fetch when req_write=0 and req_prot[0]=0. With req_prot[1]=0 (user mode), the user enable for that type decides the result.
- R6: With req_prot[1]=1 (supervisor mode), field bits 4:3 decide the rights. 00 allows read, write and execute. 01 allows read and execute. 10 allows read and write. 11 reuses the user enables. Field bit 5 has no effect on the result.
- R7: For master m in 4..7, bit 24+2(m-4) is the write enable and the bit above it is the read enable. req_write alone picks which one applies, and req_prot has no effect.
- R8: Masters 8 to 15 always get resp_error.
- R9: A write on the cfg port has cfg_addr = {region index, slot[2:0]}. Slot 0 sets start, slot 1 sets end, slot 2 sets the permission word and clears valid, and slot 3 sets valid from cfg_wdata[0]. Slots 5 to 7 change nothing. A write at one edge applies to requests sampled at the following edge.
- R10: Slot 4 (the alias) replaces the permission word and leaves the valid flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | RGN_W+3 | Region index and slot select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address |
| req_master | input | 4 | Requesting master number |
| req_write | input | 1 | 1 for write, 0 for read or fetch |
| req_prot | input | 2 | Bit 0: data access; bit 1: supervisor mode |
| resp_valid | output | 1 | Result present (one cycle after request) |
| resp_grant | output | 1 | Access allowed |
| resp_error | output | 1 | Access refused |

## Verification
The hardest case to reach is two valid regions that overlap, where one denies a request and the other grants it. This case also has to be checked right after a permission-word write has taken one of those regions out of play. The stimulus builds a deny-heavy region and a partly overlapping read-only region. It then sweeps every master number, write flag and protection code at addresses inside the overlap, inside each region alone, and on the inclusive bounds. It repeats the sweep after main-slot writes, alias writes, valid-flag writes and writes to unused slots. A bench model decides each expected result and holds it in a scoreboard queue until the response arrives.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;

  localparam int unsigned PERM_W  = 32;
  localparam int unsigned FLD_W   = 6;
  localparam int unsigned DMA_LSB = 24;

  // Region 0 reset rights: user rwx for CPU masters, rd+wr for engines
  localparam logic [PERM_W-1:0] PERM_ALL = 32'hFF1C71C7;

  typedef enum logic [2:0] {
    SLOT_LO    = 3'd0,
    SLOT_HI    = 3'd1,
    SLOT_PERM  = 3'd2,
    SLOT_VALID = 3'd3,
    SLOT_ALIAS = 3'd4
  } slot_e;

  typedef enum logic [1:0] {
    KIND_RD = 2'd0,
    KIND_WR = 2'd1,
    KIND_EX = 2'd2
  } kind_e;

  function automatic kind_e access_kind(input logic wr, input logic [1:0] prot);
    if (wr)           return KIND_WR;
    else if (prot[0]) return KIND_RD;
    else              return KIND_EX;
  endfunction

  // returns {read, write, execute}
  function automatic logic [2:0] cpu_rights(input logic [FLD_W-1:0] fld, input logic sup);
    logic [2:0] usr;
    usr = {fld[2], fld[1], fld[0]};
    if (!sup) return usr;
    case (fld[4:3])
      2'b00:   return 3'b111;
      2'b01:   return 3'b101;
      2'b10:   return 3'b110;
      default: return usr;
    endcase
  endfunction

  function automatic logic kind_ok(input logic [2:0] rwx, input kind_e k);
    case (k)
      KIND_RD: return rwx[2];
      KIND_WR: return rwx[1];
      KIND_EX: return rwx[0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic master_ok(input logic [PERM_W-1:0] perm, input logic [3:0] mst,
                                     input logic wr, input logic [1:0] prot);
    logic [FLD_W-1:0] fld;
    logic [1:0]       pair;
    int unsigned      idx;
    idx  = int'(mst[1:0]);
    fld  = perm[FLD_W*idx +: FLD_W];
    pair = perm[DMA_LSB + 2*idx +: 2];
    if (mst[3])       return 1'b0;
    else if (!mst[2]) return kind_ok(cpu_rights(fld, prot[1]), access_kind(wr, prot));
    else              return wr ? pair[0] : pair[1];
  endfunction

endpackage

// File: rtl/rgn_table.sv
module rgn_table
  import rgn_guard_pkg::*;
#(
  parameter int NUM_RGN = 4,
  parameter int ADDR_W  = 32,
  parameter int RGN_W   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [RGN_W-1:0]                 cfg_rgn,
  input  slot_e                            cfg_slot,
  input  logic [PERM_W-1:0]                cfg_wdata,
  output logic [NUM_RGN-1:0][ADDR_W-1:0]   rgn_lo,
  output logic [NUM_RGN-1:0][ADDR_W-1:0]   rgn_hi,
  output logic [NUM_RGN-1:0][PERM_W-1:0]   rgn_perm,
  output logic [NUM_RGN-1:0]               rgn_vld
);

  logic [NUM_RGN-1:0] sel_rgn;
  logic [NUM_RGN-1:0] perm_wr_ev;
  logic [NUM_RGN-1:0] alias_wr_ev;

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    assign sel_rgn[r]     = cfg_we && (cfg_rgn == RGN_W'(r));
    assign perm_wr_ev[r]  = sel_rgn[r] && (cfg_slot == SLOT_PERM);
    assign alias_wr_ev[r] = sel_rgn[r] && (cfg_slot == SLOT_ALIAS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rgn_lo[r]   <= '0;
        rgn_hi[r]   <= (r == 0) ? {ADDR_W{1'b1}} : '0;
        rgn_perm[r] <= (r == 0) ? PERM_ALL : '0;
        rgn_vld[r]  <= (r == 0);
      end else if (sel_rgn[r]) begin
        case (cfg_slot)
          SLOT_LO:    rgn_lo[r] <= cfg_wdata[ADDR_W-1:0];
          SLOT_HI:    rgn_hi[r] <= cfg_wdata[ADDR_W-1:0];
          SLOT_PERM: begin
            rgn_perm[r] <= cfg_wdata;
            rgn_vld[r]  <= 1'b0;
          end
          SLOT_VALID: rgn_vld[r]  <= cfg_wdata[0];
          SLOT_ALIAS: rgn_perm[r] <= cfg_wdata;
          default: ;
        endcase
      end
    end

    AST_PERM_WR_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
      perm_wr_ev[r] |=> !rgn_vld[r]); // R9
    AST_ALIAS_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      alias_wr_ev[r] |=> $stable(rgn_vld[r])); // R10
    AST_ALIAS_LOADS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      alias_wr_ev[r] |=> (rgn_perm[r] == $past(cfg_wdata))); // R10
  end

  if (ADDR_W < PERM_W) begin : g_wdata_hi
    logic unused_hi;
    assign unused_hi = ^cfg_wdata[PERM_W-1:ADDR_W];
  end

endmodule

// File: rtl/rgn_match.sv
module rgn_match
  import rgn_guard_pkg::*;
#(
  parameter int NUM_RGN = 4,
  parameter int ADDR_W  = 32
) (
  input  logic [NUM_RGN-1:0][ADDR_W-1:0]   rgn_lo,
  input  logic [NUM_RGN-1:0][ADDR_W-1:0]   rgn_hi,
  input  logic [NUM_RGN-1:0][PERM_W-1:0]   rgn_perm,
  input  logic [NUM_RGN-1:0]               rgn_vld,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [3:0]                       req_master,
  input  logic                             req_write,
  input  logic [1:0]                       req_prot,
  output logic [NUM_RGN-1:0]               hit_vec,
  output logic [NUM_RGN-1:0]               ok_vec
);

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_cmp
    logic above_lo, below_hi;
    assign above_lo   = (req_addr >= rgn_lo[r]);
    assign below_hi   = (req_addr <= rgn_hi[r]);
    assign hit_vec[r] = rgn_vld[r] && above_lo && below_hi;
    assign ok_vec[r]  = hit_vec[r] && master_ok(rgn_perm[r], req_master, req_write, req_prot);
  end

endmodule

// File: rtl/rgn_resp.sv
module rgn_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic any_ok,
  output logic resp_valid,
  output logic resp_grant,
  output logic resp_error
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
      resp_error <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_grant <= req_valid && any_ok;
      resp_error <= req_valid && !any_ok;
    end
  end

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid); // R2
  AST_IDLE_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!resp_valid && !resp_grant && !resp_error)); // R2
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot({resp_grant, resp_error})); // R2

endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
  import rgn_guard_pkg::*;
#(
  parameter  int NUM_RGN = 4,
  parameter  int ADDR_W  = 32,
  localparam int RGN_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1,
  localparam int CFG_AW  = RGN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_master,
  input  logic              req_write,
  input  logic [1:0]        req_prot,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic              resp_error
);

  logic [NUM_RGN-1:0][ADDR_W-1:0] rgn_lo, rgn_hi;
  logic [NUM_RGN-1:0][PERM_W-1:0] rgn_perm;
  logic [NUM_RGN-1:0]             rgn_vld;
  logic [NUM_RGN-1:0]             hit_vec, ok_vec;
  logic                           any_hit, any_ok;
  slot_e                          cfg_slot;
  logic [RGN_W-1:0]               cfg_rgn;

  assign cfg_slot = slot_e'(cfg_addr[2:0]);
  assign cfg_rgn  = cfg_addr[CFG_AW-1:3];

  rgn_table #(.NUM_RGN(NUM_RGN), .ADDR_W(ADDR_W), .RGN_W(RGN_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rgn(cfg_rgn), .cfg_slot(cfg_slot),
    .cfg_wdata(cfg_wdata), .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .rgn_perm(rgn_perm),
    .rgn_vld(rgn_vld)
  );

  rgn_match #(.NUM_RGN(NUM_RGN), .ADDR_W(ADDR_W)) u_match (
    .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .rgn_perm(rgn_perm), .rgn_vld(rgn_vld),
    .req_addr(req_addr), .req_master(req_master), .req_write(req_write),
    .req_prot(req_prot), .hit_vec(hit_vec), .ok_vec(ok_vec)
  );

  assign any_hit = |hit_vec;
  assign any_ok  = |ok_vec;

  rgn_resp u_resp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .any_ok(any_ok),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_error(resp_error)
  );

  AST_MISS_IS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_hit) |=> resp_error); // R3
  AST_ANY_REGION_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && any_ok) |=> resp_grant); // R4
  AST_FOREIGN_MASTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_master[3]) |=> resp_error); // R8
  AST_CFG_SLOT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !$isunknown(cfg_addr)); // R9

endmodule

// File: tb/rgn_guard_tb_top.sv
`timescale 1ns/1ps
module rgn_guard_tb_top;

  localparam int NRG = 4;
  localparam int AW  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_master = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_prot = '0;
  logic        resp_valid, resp_grant, resp_error;

  always #4 clk = ~clk;

  rgn_guard #(.NUM_RGN(NRG), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_master(req_master),
    .req_write(req_write), .req_prot(req_prot), .resp_valid(resp_valid),
    .resp_grant(resp_grant), .resp_error(resp_error)
  );

  typedef struct { bit exp; string tag; } item_t;
  item_t sb_q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bit [31:0] m_lo[NRG], m_hi[NRG], m_perm[NRG];
  bit        m_vld[NRG];

  function automatic bit ref_allow(int m, bit w, bit [1:0] p, bit [31:0] pw);
    int b;
    bit ux, uw, ur, r, wr, x;
    bit [1:0] s;
    if (m >= 8) return 1'b0;
    if (m >= 4) begin
      b = 24 + 2 * (m - 4);
      return w ? pw[b] : pw[b+1];
    end
    b  = 6 * m;
    ux = pw[b]; uw = pw[b+1]; ur = pw[b+2];
    s  = {pw[b+4], pw[b+3]};
    if (p[1] && s != 2'b11) begin
      r = 1'b1; wr = (s != 2'b01); x = (s != 2'b10);
    end else begin
      r = ur; wr = uw; x = ux;
    end
    if (w) return wr;
    if (p[0]) return r;
    return x;
  endfunction

  function automatic bit ref_expect(bit [31:0] a, int m, bit w, bit [1:0] p);
    for (int r = 0; r < NRG; r++)
      if (m_vld[r] && a >= m_lo[r] && a <= m_hi[r] && ref_allow(m, w, p, m_perm[r]))
        return 1'b1;
    return 1'b0;
  endfunction

  task automatic cfg_write(int rg, bit [2:0] slot, bit [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we    = 1'b1;
    cfg_addr  = {rg[1:0], slot};
    cfg_wdata = d;
    case (slot)
      3'd0: m_lo[rg] = d;
      3'd1: m_hi[rg] = d;
      3'd2: begin m_perm[rg] = d; m_vld[rg] = 1'b0; end
      3'd3: m_vld[rg] = d[0];
      3'd4: m_perm[rg] = d;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic req_send(bit [31:0] a, int m, bit w, bit [1:0] p, string tag);
    item_t it;
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = a;
    req_master = m[3:0];
    req_write  = w;
    req_prot   = p;
    it.exp = ref_expect(a, m, w, p);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic sweep(bit [31:0] a, string base);
    string cls;
    for (int m = 0; m < 10; m++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 4; p++) begin
          if (m >= 8)      cls = "R8";
          else if (m >= 4) cls = "R7";
          else if (p >= 2) cls = "R6";
          else             cls = "R5";
          req_send(a, m, w[0], p[1:0], $sformatf("%s/%s", base, cls));
        end
  endtask

  // monitor: compares each response with the scoreboard head
  always @(negedge clk) begin
    item_t it;
    if (rst_n && resp_valid) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected response: grant=%0b error=%0b expected none",
                 resp_grant, resp_error);
      end else begin
        it = sb_q.pop_front();
        if (resp_grant !== it.exp || resp_error !== !it.exp) begin
          n_fail++;
          $display("FAIL %s addr/master mismatch: grant=%0b error=%0b expected grant=%0b",
                   it.tag, resp_grant, resp_error, it.exp);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NRG; r++) begin
      m_lo[r] = '0; m_hi[r] = '0; m_perm[r] = '0; m_vld[r] = 1'b0;
    end
    m_hi[0] = 32'hFFFF_FFFF; m_perm[0] = 32'hFF1C71C7; m_vld[0] = 1'b1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (resp_valid !== 1'b0 || resp_grant !== 1'b0 || resp_error !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: %0b%0b%0b expected 000", resp_valid, resp_grant, resp_error);
    end

    // reset region 0 covers everything with full rights
    sweep(32'h0000_0000, "R1");
    sweep(32'hFFFF_FFFF, "R1");

    // region 1: deny-heavy mixed rights
    cfg_write(1, 3'd0, 32'h0000_1000);
    cfg_write(1, 3'd1, 32'h0000_1FFF);
    cfg_write(1, 3'd2, {8'h39, 6'h24, 6'h08, 6'h1A, 6'h15});
    cfg_write(1, 3'd3, 32'h1);

    // R9: main-slot perm write invalidates region 0
    cfg_write(0, 3'd2, 32'hFFFF_FFFF);
    sweep(32'h0000_0100, "R9");
    sweep(32'h0000_1000, "R3");
    sweep(32'h0000_1FFF, "R3");
    sweep(32'h0000_0FFF, "R3");
    sweep(32'h0000_2000, "R3");

    // R9: rewriting perm on region 1 removes it, then revalidate
    cfg_write(1, 3'd2, {8'h39, 6'h24, 6'h08, 6'h1A, 6'h15});
    sweep(32'h0000_1800, "R9");
    cfg_write(1, 3'd3, 32'h1);

    // R10: alias keeps region valid
    cfg_write(1, 3'd4, {8'hC6, 6'h2D, 6'h12, 6'h07, 6'h38});
    sweep(32'h0000_1800, "R10");

    // R4: overlapping read-only region 2
    cfg_write(2, 3'd0, 32'h0000_1800);
    cfg_write(2, 3'd1, 32'h0000_27FF);
    cfg_write(2, 3'd2, {8'hAA, 6'h1C, 6'h1C, 6'h1C, 6'h1C});
    cfg_write(2, 3'd3, 32'h1);
    sweep(32'h0000_1900, "R4");
    sweep(32'h0000_2400, "R4");

    // R9: valid-flag clear and unused slot
    cfg_write(1, 3'd3, 32'h0);
    sweep(32'h0000_1900, "R9");
    cfg_write(2, 3'd5, 32'h0);
    cfg_write(2, 3'd7, 32'h0);
    sweep(32'h0000_2400, "R9");

    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing responses: %0d outstanding expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule